// File: doc/BRIEF.md
# DC-Balanced Lane Word Encoder

This block codes one lane's data word per accepted transfer for a DC-coupled serial link. In balance mode it either forwards the word or inverts every bit, and it sets a flag bit above the data that tells the far end which choice was made. The choice is driven by a signed running-disparity register. This register records how far the lane has drifted towards ones or zeros. It is kept inside a fixed, asymmetric window so that the line's long-term bias stays near zero. With balance mode off, the word passes through unchanged, with a zero flag, and the running disparity is left alone.

Words enter and leave on valid/ready streams. The coded word sits in one output register. The upstream side may present a word whenever `in_ready` is high. A transfer happens on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the coded word is held and no new word is taken. `bal_en` is a plain control pin. It is sampled with each accepted word.

Top module: `dcb_lane_encoder`

## Requirements
- R1: A synchronous reset (`rst_n` low at a rising edge) clears the running disparity to 0 and empties the output register (`out_valid` low).
- R2: A word accepted with `bal_en` low is output as {1'b0, data}. The running disparity is not changed by it, which is visible in the coding of later balance-mode words.
- R3: The word disparity is the count of 1 bits minus the count of 0 bits (range -6..+6). A word disparity of zero is classed as negative, and so is a running disparity of zero. In balance mode the word is inverted exactly when both values fall in the same class (both positive, or both negative-or-zero).
- R4: The coded word is 7 bits wide. Bit 6 is the flag and bits 5..0 are the payload. An inverted word is output as {1'b1, ~data}; a word that is not inverted is output as {1'b0, data}.
- R5: For each word accepted in balance mode, the running disparity gains (word disparity - 1) if the word was sent unmodified, or (1 - word disparity) if it was inverted.
- R6: The running disparity saturates, and never leaves the range -6 to +7.
- R7: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` low, `out_valid` stays high and `out_word` stays stable.
- R8: Every output word decodes back to its input data: the payload is inverted when bit 6 is 1 and taken as-is when bit 6 is 0. Words leave in the order they were accepted.
- R9: The running disparity changes only on a rising edge where a word is accepted with `bal_en` high. Stalled or idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bal_en | input | 1 | Balance mode enable, sampled with each accepted word |
| in_valid | input | 1 | Upstream word present |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | 6 | Lane data word |
| out_valid | output | 1 | Coded word present |
| out_ready | input | 1 | Downstream takes the coded word this cycle |
| out_word | output | 7 | Coded word, flag in bit 6 |

## Verification
The assertions take for granted that reset is held low from time zero through at least one rising edge. They do not require `in_valid` to be held under back-pressure or `bal_en` to be steady; either may change on any cycle, and only the accepted transfer matters. The stimulus drives every input half a period away from the active edge. It mixes fixed-seed random data, random `bal_en` toggles and a randomly withheld `out_ready`, so stalls, idle gaps and mode changes all occur. Directed sequences start from the reset value and cover the zero-disparity class, a full-scale jump to the upper bound, and a pass-through word placed between balance-mode words.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

  typedef enum logic {
    SGN_NEG_ZERO = 1'b0,
    SGN_POS      = 1'b1
  } dcb_sign_e;

  localparam int DCB_DATA_W = 6;
  localparam int DCB_RD_W   = 5;

endpackage

// File: rtl/dcb_word_disp.sv
module dcb_word_disp #(
  parameter int DATA_W = 6,
  parameter int DW     = 4
) (
  input  logic [DATA_W-1:0]     word,
  output logic signed [DW-1:0]  disp
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [CNT_W-1:0] ones_acc [DATA_W+1];

  assign ones_acc[0] = '0;

  generate
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_cnt
      assign ones_acc[gi+1] = ones_acc[gi] + CNT_W'(word[gi]);
    end
  endgenerate

  // ones - zeros = 2*ones - DATA_W
  logic signed [DW-1:0] twice_ones;
  assign twice_ones = $signed(DW'({ones_acc[DATA_W], 1'b0}));
  assign disp       = twice_ones - $signed(DW'(DATA_W));

endmodule

// File: rtl/dcb_flip_decide.sv
module dcb_flip_decide
  import dcb_pkg::*;
#(
  parameter int DW   = 4,
  parameter int RD_W = 5,
  parameter int CW   = 5
) (
  input  logic                  en,
  input  logic signed [DW-1:0]  wd,
  input  logic signed [RD_W-1:0] rd,
  output logic                  invert,
  output logic signed [CW-1:0]  contrib
);
  dcb_sign_e wd_cls;
  dcb_sign_e rd_cls;
  logic signed [CW-1:0] wd_x;
  logic signed [CW-1:0] one_x;

  always_comb begin
    wd_cls = (!wd[DW-1] && (wd != '0)) ? SGN_POS : SGN_NEG_ZERO;
    rd_cls = (!rd[RD_W-1] && (rd != '0)) ? SGN_POS : SGN_NEG_ZERO;
    invert = en && (wd_cls == rd_cls);
    wd_x   = CW'(wd);
    one_x  = CW'(1);
    contrib = invert ? (one_x - wd_x) : (wd_x - one_x);
  end

endmodule

// File: rtl/dcb_rd_acc.sv
module dcb_rd_acc #(
  parameter int RD_W   = 5,
  parameter int CW     = 5,
  parameter int RD_MAX = 7,
  parameter int RD_MIN = -6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   upd,
  input  logic signed [CW-1:0]   contrib,
  output logic signed [RD_W-1:0] rd_q
);
  localparam int SW = ((RD_W > CW) ? RD_W : CW) + 1;
  localparam logic signed [SW-1:0] S_MAX = SW'(RD_MAX);
  localparam logic signed [SW-1:0] S_MIN = SW'(RD_MIN);

  logic signed [SW-1:0]   sum;
  logic signed [SW-1:0]   clamped;

  always_comb begin
    sum = SW'(rd_q) + SW'(contrib);
    if (sum > S_MAX)      clamped = S_MAX;
    else if (sum < S_MIN) clamped = S_MIN;
    else                  clamped = sum;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   rd_q <= '0;
    else if (upd) rd_q <= RD_W'(clamped);
  end

endmodule

// File: rtl/dcb_lane_encoder.sv
module dcb_lane_encoder
  import dcb_pkg::*;
#(
  parameter int DATA_W = DCB_DATA_W,
  parameter int RD_W   = DCB_RD_W,
  parameter int RD_MAX = 7,
  parameter int RD_MIN = -6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bal_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W:0]   out_word
);
  localparam int DW = $clog2(DATA_W + 1) + 1;
  localparam int CW = DW + 1;

  logic signed [DW-1:0]   wd;
  logic signed [RD_W-1:0] rd_q;
  logic                   invert;
  logic signed [CW-1:0]   contrib;
  logic                   accept;
  logic [DATA_W:0]        coded;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  dcb_word_disp #(.DATA_W(DATA_W), .DW(DW)) u_disp (
    .word (in_data),
    .disp (wd)
  );

  dcb_flip_decide #(.DW(DW), .RD_W(RD_W), .CW(CW)) u_dec (
    .en      (bal_en),
    .wd      (wd),
    .rd      (rd_q),
    .invert  (invert),
    .contrib (contrib)
  );

  dcb_rd_acc #(.RD_W(RD_W), .CW(CW), .RD_MAX(RD_MAX), .RD_MIN(RD_MIN)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (accept && bal_en),
    .contrib (contrib),
    .rd_q    (rd_q)
  );

  assign coded = invert ? {1'b1, ~in_data} : {1'b0, in_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_word <= coded;
    end
  end

endmodule

// File: rtl/dcb_lane_encoder_chk.sv
module dcb_lane_encoder_chk #(
  parameter int DATA_W = 6,
  parameter int RD_W   = 5,
  parameter int RD_MAX = 7,
  parameter int RD_MIN = -6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bal_en,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic [DATA_W-1:0]      in_data,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [DATA_W:0]        out_word,
  input logic signed [RD_W-1:0] rd_q
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= !rst_n;

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rst_d |-> (rd_q == '0) && !out_valid); // R1

  AST_PASS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !bal_en) |=> (out_word == {1'b0, $past(in_data)})); // R2

  AST_RD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_q) <= RD_MAX) && (int'(rd_q) >= RD_MIN)); // R6

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_word)); // R7

  AST_READY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R7

  AST_RD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready && bal_en) |=> $stable(rd_q)); // R9

endmodule

bind dcb_lane_encoder dcb_lane_encoder_chk #(
  .DATA_W(DATA_W), .RD_W(RD_W), .RD_MAX(RD_MAX), .RD_MIN(RD_MIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bal_en(bal_en), .in_valid(in_valid),
  .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
  .out_ready(out_ready), .out_word(out_word), .rd_q(rd_q)
);

// File: tb/dcb_lane_encoder_tb.sv
module dcb_lane_encoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bal_en = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [5:0] in_data = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [6:0] out_word;

  int n_checks = 0;
  int n_fail   = 0;
  int rd_m     = 0;
  bit done     = 0;
  bit stall_p  = 0;
  logic [6:0] held_word;
  logic [6:0] exp_q[$];
  logic [5:0] dat_q[$];

  always #2 clk = ~clk;

  dcb_lane_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .bal_en(bal_en), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word)
  );

  function automatic int wdisp(input logic [5:0] d);
    int ones = 0;
    for (int i = 0; i < 6; i++) ones += int'(d[i]);
    return 2 * ones - 6;
  endfunction

  // Reference coder: R3 R4 R5 R6
  function automatic logic [6:0] ref_encode(input logic [5:0] d, input bit en);
    int  wd;
    bit  inv;
    if (!en) return {1'b0, d};
    wd  = wdisp(d);
    inv = ((rd_m > 0) == (wd > 0));
    rd_m = rd_m + (inv ? (1 - wd) : (wd - 1));
    if (rd_m > 7)  rd_m = 7;
    if (rd_m < -6) rd_m = -6;
    return inv ? {1'b1, ~d} : {1'b0, d};
  endfunction

  task automatic check(input bit ok, input string req, input logic [6:0] act, input logic [6:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [5:0] d, input bit en, input bit ordy);
    logic [6:0] e;
    logic [5:0] dd;
    @(negedge clk);
    if (stall_p) check(out_valid && out_word == held_word, "R7 hold", out_word, held_word);
    in_valid = v; in_data = d; bal_en = en; out_ready = ordy;
    #1;
    check(in_ready == (!out_valid || out_ready), "R7 ready", {6'b0, in_ready}, {6'b0, !out_valid || out_ready});
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected word", out_word, 7'h0);
      end else begin
        e = exp_q.pop_front();
        dd = dat_q.pop_front();
        check(out_word == e, "R3 R4 R5 R6 R2 coded word", out_word, e);
        check((out_word[6] ? ~out_word[5:0] : out_word[5:0]) == dd, "R8 decode",
              {1'b0, out_word[6] ? ~out_word[5:0] : out_word[5:0]}, {1'b0, dd});
      end
    end
    if (in_valid && in_ready) begin
      exp_q.push_back(ref_encode(d, en));
      dat_q.push_back(d);
    end
    stall_p   = out_valid && !out_ready;
    held_word = out_word;
  endtask

  task automatic drain();
    for (int i = 0; i < 8; i++) step(1'b0, 6'h0, 1'b0, 1'b1);
    check(exp_q.size() == 0, "R8 drained", 7'(exp_q.size()), 7'h0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0c0d));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: output register empty after reset
    check(!out_valid, "R1 out_valid after reset", {6'b0, out_valid}, 7'h0);
    check(in_ready, "R1 in_ready after reset", {6'b0, in_ready}, 7'h1);

    // Directed: rd=0 neg, 0x00 wd=-6 neg -> invert, 0x7F, rd becomes 7 (R3 R4 R5)
    step(1'b1, 6'h00, 1'b1, 1'b1);
    // R2: pass-through, rd must stay at 7
    step(1'b1, 6'h00, 1'b0, 1'b1);
    // rd=7 pos, 0x3F pos -> invert, 0x40 (only if R2 left rd untouched), rd=2
    step(1'b1, 6'h3F, 1'b1, 1'b1);
    // R3: wd=0 neg class, rd=2 pos -> as-is 0x07
    step(1'b1, 6'h07, 1'b1, 1'b1);
    drain();
    check(rd_m == 1, "R5 model track", 7'(rd_m), 7'd1);

    // R7 R9: stall with a pending word; rd frozen meanwhile
    step(1'b1, 6'h15, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b1, 6'h00, 1'b1, 1'b0);
    drain();

    // Random traffic with back-pressure and mode toggles (R2..R9)
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) != 0, 6'($urandom), ($urandom % 8) != 0, ($urandom % 10) < 7);
    end
    drain();

    // R1: reset mid-stream returns rd to 0
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd_m = 0; exp_q.delete(); dat_q.delete(); stall_p = 0;
    #1;
    check(!out_valid, "R1 out_valid after second reset", {6'b0, out_valid}, 7'h0);
    step(1'b1, 6'h01, 1'b1, 1'b1); // wd=-4, rd=0 -> invert 0x7E
    step(1'b1, 6'h3E, 1'b1, 1'b1);
    drain();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule